// File: doc/BRIEF.md
# Audio Output Power Sequencer

This block steps the headphone-style outputs of an audio converter through power-up and power-down so that the series DC-blocking capacitors charge and discharge slowly and no audible thump reaches the load. It runs on the system clock and uses rising edges of the frame clock as its time base for the long phases. A short system-clock delay serves the fast path.

After reset a standalone start-up timer runs. If it expires, the outputs power up on their own and the block stays in standalone operation. A write of the control-port enable bit before expiry cancels that timer. It also asks the register file for one cycle to reload its defaults. From then on the power-down bit decides when the outputs come up and go down. With soft ramp enabled, power-up clamps the outputs to ground, then ramps them to the quiescent level, and only then enables audio. Power-down stops audio, waits one cycle with nothing attached, and then replaces the output buffers with a discharge sink for a timed interval.

Top module: `popseq_top`

## Requirements
- R1: While `rstN` is low, `phase` is 0, `regDefault` and `clampEn` are 1, and `rampEn`, `audioEn`, `bufConnect` and `sinkEn` are 0.
- R2: After `rstN` rises, `phase` is 1 for exactly `SA_FRAMES` rising frame-clock edges. It then leaves phase 1 and starts power-up without any register write.
- R3: If `cpEn` is 1 while `phase` is 1, `regDefault` is 1 in that cycle. The next cycle shows `phase` 2 and `regDefault` 0, and the standalone power-up never happens.
- R4: In control-port mode the block stays at `phase` 2, with `clampEn` 1, for as long as `pdnBit` is 1, however many frame edges pass. A 0 on `pdnBit` starts power-up.
- R5: With `softRampEn` 0, power-up takes `SHORT_CYCLES` system clocks at `phase` 4 with `rampEn` 1. It then takes one idle cycle before `phase` 5.
- R6: With `softRampEn` 1, power-up holds `phase` 3 with `clampEn` 1 for `CLAMP_FRAMES` frame edges. It then holds `phase` 4 with `rampEn` 1 for `RAMP_FRAMES` frame edges. Only after that do `audioEn` and `bufConnect` go to 1 at `phase` 5.
- R7: A power-down request in `phase` 5 first drops `audioEn` while `bufConnect` stays 1 for one cycle. The next cycle has both `bufConnect` and `sinkEn` at 0. The cycle after that raises `sinkEn`. `bufConnect` and `sinkEn` are never 1 together.
- R8: A power-down request during clamp, ramp or the short delay goes straight to discharge (`phase` 6, `sinkEn` 1) on the next cycle.
- R9: Discharge lasts `DISCH_FRAMES` frame edges, and a 0 on `pdnBit` during it is ignored. At expiry the block enters idle (`phase` 2) and restarts power-up if `pdnBit` is 0.
- R10: The `phase` codes are: 0 reset, 1 standalone, 2 idle powered down, 3 clamp, 4 ramp, 5 active, 6 discharge. The short delay and the one-cycle connect gap report 4. The mute cycle and the disconnect gap report 6.
- R11: Once the standalone timer has expired, `cpEn` and `pdnBit` have no effect and `phase` 5 holds until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lrck | input | 1 | Frame clock, asynchronous to clk |
| cpEn | input | 1 | Control-port enable register bit |
| pdnBit | input | 1 | Power-down register bit (1 = down) |
| softRampEn | input | 1 | Selects clamp-and-ramp power-up |
| clampEn | output | 1 | Clamp outputs to ground |
| rampEn | output | 1 | Quiescent-level ramp enable |
| audioEn | output | 1 | Audio output enable |
| bufConnect | output | 1 | Output buffers connected to pins |
| sinkEn | output | 1 | Discharge current sink enable |
| regDefault | output | 1 | Request register file to load defaults |
| phase | output | 3 | Current phase code |

## Verification
The bench builds the block with a standalone length of 8 frame edges, a clamp of 4, a ramp of 6, a discharge of 5 and a short delay of 20 clocks. With these values every phase boundary can be reached in a few hundred cycles. Each boundary is probed one frame edge before expiry and again at expiry. The same values let the bench run a complete power-up, power-down and restart in every start path, and abort from both the clamp and the ramp phase.

// File: rtl/popseq_pkg.sv
package popseq_pkg;

  typedef enum logic [3:0] {
    S_RESET, S_STANDALONE, S_IDLE, S_CLAMP, S_RAMP, S_SHORT,
    S_CONNECT, S_ACTIVE, S_MUTE, S_GAP, S_DISCH
  } seqState_t;

  typedef enum logic [2:0] {
    T_STANDALONE, T_CLAMP, T_RAMP, T_SHORT, T_DISCH
  } timerSel_t;

  typedef struct packed {
    logic      clear;
    logic      run;
    timerSel_t sel;
  } timerCmd_t;

  localparam logic [2:0] PH_RESET      = 3'd0;
  localparam logic [2:0] PH_STANDALONE = 3'd1;
  localparam logic [2:0] PH_IDLE       = 3'd2;
  localparam logic [2:0] PH_CLAMP      = 3'd3;
  localparam logic [2:0] PH_RAMP       = 3'd4;
  localparam logic [2:0] PH_ACTIVE     = 3'd5;
  localparam logic [2:0] PH_DISCH      = 3'd6;

endpackage

// File: rtl/popseq_timer.sv
module popseq_timer
  import popseq_pkg::*;
#(
  parameter int SA_FRAMES    = 1024,
  parameter int CLAMP_FRAMES = 1000,
  parameter int RAMP_FRAMES  = 10000,
  parameter int DISCH_FRAMES = 8192,
  parameter int SHORT_CYCLES = 5000
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      lrck,
  input  timerCmd_t cmd,
  output logic      expired
);

  localparam int MAX_A = (SA_FRAMES > CLAMP_FRAMES) ? SA_FRAMES : CLAMP_FRAMES;
  localparam int MAX_B = (RAMP_FRAMES > DISCH_FRAMES) ? RAMP_FRAMES : DISCH_FRAMES;
  localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_V = (MAX_C > SHORT_CYCLES) ? MAX_C : SHORT_CYCLES;
  localparam int CNT_W = $clog2(MAX_V + 1);

  logic lrckMeta, lrckSync, lrckPrev;
  logic frameTick, advance, frameBased;
  logic [CNT_W-1:0] cnt, limit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lrckMeta <= 1'b0;
      lrckSync <= 1'b0;
      lrckPrev <= 1'b0;
    end else begin
      lrckMeta <= lrck;
      lrckSync <= lrckMeta;
      lrckPrev <= lrckSync;
    end
  end

  assign frameTick = lrckSync & ~lrckPrev;

  always_comb begin
    unique case (cmd.sel)
      T_STANDALONE: limit = CNT_W'(SA_FRAMES);
      T_CLAMP:      limit = CNT_W'(CLAMP_FRAMES);
      T_RAMP:       limit = CNT_W'(RAMP_FRAMES);
      T_DISCH:      limit = CNT_W'(DISCH_FRAMES);
      default:      limit = CNT_W'(SHORT_CYCLES);
    endcase
  end

  assign frameBased = (cmd.sel != T_SHORT);
  assign advance    = cmd.run & (frameBased ? frameTick : 1'b1);
  assign expired    = advance && (cnt == limit - CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          cnt <= '0;
    else if (cmd.clear) cnt <= '0;
    else if (advance)   cnt <= cnt + CNT_W'(1);
  end

  // R6 / R9: a running phase count never passes its own limit
  p_cnt_in_range_r6: assert property (@(posedge clk) disable iff (!rstN)
    cmd.run |-> (cnt < limit));

  // R2: only rising frame-clock edges advance, so ticks are never back to back
  p_tick_spaced_r2: assert property (@(posedge clk) disable iff (!rstN)
    frameTick |=> !frameTick);

endmodule

// File: rtl/popseq_ctrl.sv
module popseq_ctrl
  import popseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cpEn,
  input  logic       pdnBit,
  input  logic       softRampEn,
  input  logic       expired,
  output timerCmd_t  cmd,
  output logic       clampEn,
  output logic       rampEn,
  output logic       audioEn,
  output logic       bufConnect,
  output logic       sinkEn,
  output logic       regDefault,
  output logic [2:0] phase
);

  seqState_t state, nextState;
  logic cpMode, pdReq;
  seqState_t upState;

  assign pdReq   = cpMode & pdnBit;
  assign upState = softRampEn ? S_CLAMP : S_SHORT;

  always_comb begin
    nextState = state;
    unique case (state)
      S_RESET:      nextState = S_STANDALONE;
      S_STANDALONE: if (cpEn) nextState = S_IDLE;
                    else if (expired) nextState = upState;
      S_IDLE:       if (!pdnBit) nextState = upState;
      S_CLAMP:      if (pdReq) nextState = S_DISCH;
                    else if (expired) nextState = S_RAMP;
      S_RAMP,
      S_SHORT:      if (pdReq) nextState = S_DISCH;
                    else if (expired) nextState = S_CONNECT;
      S_CONNECT:    nextState = S_ACTIVE;
      S_ACTIVE:     if (pdReq) nextState = S_MUTE;
      S_MUTE:       nextState = S_GAP;
      S_GAP:        nextState = S_DISCH;
      S_DISCH:      if (expired) nextState = S_IDLE;
      default:      nextState = S_RESET;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_RESET;
      cpMode <= 1'b0;
    end else begin
      state <= nextState;
      if (state == S_STANDALONE && cpEn) cpMode <= 1'b1;
    end
  end

  always_comb begin
    cmd.clear = (nextState != state);
    cmd.run   = 1'b1;
    unique case (state)
      S_STANDALONE: cmd.sel = T_STANDALONE;
      S_CLAMP:      cmd.sel = T_CLAMP;
      S_RAMP:       cmd.sel = T_RAMP;
      S_DISCH:      cmd.sel = T_DISCH;
      S_SHORT:      cmd.sel = T_SHORT;
      default: begin
        cmd.sel = T_SHORT;
        cmd.run = 1'b0;
      end
    endcase
  end

  assign clampEn    = (state == S_RESET) || (state == S_STANDALONE) ||
                      (state == S_IDLE)  || (state == S_CLAMP);
  assign rampEn     = (state == S_RAMP) || (state == S_SHORT);
  assign audioEn    = (state == S_ACTIVE);
  assign bufConnect = (state == S_ACTIVE) || (state == S_MUTE);
  assign sinkEn     = (state == S_DISCH);
  assign regDefault = (state == S_RESET) || (state == S_STANDALONE && cpEn);

  always_comb begin
    unique case (state)
      S_RESET:                 phase = PH_RESET;
      S_STANDALONE:            phase = PH_STANDALONE;
      S_IDLE:                  phase = PH_IDLE;
      S_CLAMP:                 phase = PH_CLAMP;
      S_RAMP, S_SHORT,
      S_CONNECT:               phase = PH_RAMP;
      S_ACTIVE:                phase = PH_ACTIVE;
      default:                 phase = PH_DISCH;
    endcase
  end

  // R7: break-before-make between buffers and sink, both directions
  p_gap_after_buf_r7: assert property (@(posedge clk) disable iff (!rstN)
    bufConnect |=> !sinkEn);
  p_gap_after_sink_r7: assert property (@(posedge clk) disable iff (!rstN)
    sinkEn |=> !bufConnect);
  // R7: audio already off in the cycle before buffers disconnect
  p_mute_first_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(bufConnect) |-> !$past(audioEn));
  // R6: audio only with buffers attached
  p_audio_needs_buf_r6: assert property (@(posedge clk) disable iff (!rstN)
    audioEn |-> bufConnect);
  // R10: at most one output drive mode at a time
  p_one_drive_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({clampEn, rampEn, bufConnect, sinkEn}));
  // R9: discharge is held until the timer reports expiry
  p_disch_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_DISCH && !expired) |=> (state == S_DISCH));
  // R11: standalone operation keeps outputs active
  p_standalone_locked_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!cpMode && state == S_ACTIVE) |=> (state == S_ACTIVE));

endmodule

// File: rtl/popseq_top.sv
module popseq_top
  import popseq_pkg::*;
#(
  parameter int SA_FRAMES    = 1024,
  parameter int CLAMP_FRAMES = 1000,
  parameter int RAMP_FRAMES  = 10000,
  parameter int DISCH_FRAMES = 8192,
  parameter int SHORT_CYCLES = 5000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       lrck,
  input  logic       cpEn,
  input  logic       pdnBit,
  input  logic       softRampEn,
  output logic       clampEn,
  output logic       rampEn,
  output logic       audioEn,
  output logic       bufConnect,
  output logic       sinkEn,
  output logic       regDefault,
  output logic [2:0] phase
);

  timerCmd_t timerCmd;
  logic      timerDone;

  popseq_timer #(
    .SA_FRAMES(SA_FRAMES), .CLAMP_FRAMES(CLAMP_FRAMES), .RAMP_FRAMES(RAMP_FRAMES),
    .DISCH_FRAMES(DISCH_FRAMES), .SHORT_CYCLES(SHORT_CYCLES)
  ) u_timer (
    .clk(clk), .rstN(rstN), .lrck(lrck), .cmd(timerCmd), .expired(timerDone)
  );

  popseq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cpEn(cpEn), .pdnBit(pdnBit), .softRampEn(softRampEn),
    .expired(timerDone), .cmd(timerCmd), .clampEn(clampEn), .rampEn(rampEn),
    .audioEn(audioEn), .bufConnect(bufConnect), .sinkEn(sinkEn),
    .regDefault(regDefault), .phase(phase)
  );

endmodule

// File: tb/sim_popseq_top.sv
module sim_popseq_top;

  localparam int SA = 8, CL = 4, RP = 6, DS = 5, SH = 20;

  logic clk = 1'b0, rstN = 1'b0, lrck = 1'b0;
  logic cpEn = 1'b0, pdnBit = 1'b1, softRampEn = 1'b1;
  logic clampEn, rampEn, audioEn, bufConnect, sinkEn, regDefault;
  logic [2:0] phase;
  int nChecks = 0, nFails = 0;

  always #2 clk = ~clk;

  popseq_top #(.SA_FRAMES(SA), .CLAMP_FRAMES(CL), .RAMP_FRAMES(RP),
               .DISCH_FRAMES(DS), .SHORT_CYCLES(SH)) u0 (
    .clk(clk), .rstN(rstN), .lrck(lrck), .cpEn(cpEn), .pdnBit(pdnBit),
    .softRampEn(softRampEn), .clampEn(clampEn), .rampEn(rampEn), .audioEn(audioEn),
    .bufConnect(bufConnect), .sinkEn(sinkEn), .regDefault(regDefault), .phase(phase));

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic frames(input int n);
    for (int i = 0; i < n; i++) begin
      lrck = 1'b1; repeat (4) @(negedge clk);
      lrck = 1'b0; repeat (4) @(negedge clk);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 phase", phase, 0);
    chk("R1 regDefault", regDefault, 1);
    chk("R1 clampEn", clampEn, 1);
    chk("R1 drives off", {rampEn, audioEn, bufConnect, sinkEn}, 0);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic takeover();
    doReset();
    frames(2);
    cpEn = 1'b1; #1;
    chk("R3 regDefault pulse", regDefault, 1);
    @(negedge clk); cpEn = 1'b0;
    chk("R3 regDefault low", regDefault, 0);
    chk("R3 idle phase", phase, 2);
  endtask

  task automatic testStandalone();
    softRampEn = 1'b1; pdnBit = 1'b1; cpEn = 1'b0;
    doReset();
    chk("R2 standalone phase", phase, 1);
    frames(SA - 1);
    chk("R2 before expiry", phase, 1);
    frames(1);
    chk("R2 R6 clamp phase", phase, 3);
    chk("R6 clampEn", clampEn, 1);
    frames(CL - 1);
    chk("R6 clamp held", phase, 3);
    frames(1);
    chk("R6 ramp phase", phase, 4);
    chk("R6 rampEn", rampEn, 1);
    frames(RP - 1);
    chk("R6 ramp held", phase, 4);
    chk("R6 audio still off", audioEn, 0);
    frames(1);
    chk("R6 active phase", phase, 5);
    chk("R6 audio and buffer", {audioEn, bufConnect}, 3);
    cpEn = 1'b1; pdnBit = 1'b1;
    frames(3);
    chk("R11 still active", phase, 5);
    chk("R11 audio on", audioEn, 1);
    cpEn = 1'b0;
  endtask

  task automatic testTakeover();
    pdnBit = 1'b1; softRampEn = 1'b0;
    takeover();
    frames(SA + 2);
    chk("R3 R4 idle held", phase, 2);
    chk("R4 clamp in idle", clampEn, 1);
    chk("R4 audio off", audioEn, 0);
  endtask

  task automatic testShort();
    pdnBit = 1'b0;
    repeat (SH + 1) @(negedge clk);
    chk("R5 R10 ramp code in delay", phase, 4);
    chk("R5 audio off in delay", audioEn, 0);
    repeat (2) @(negedge clk);
    chk("R5 active", phase, 5);
    chk("R5 audio on", audioEn, 1);
  endtask

  task automatic testPowerDown();
    pdnBit = 1'b1;
    @(negedge clk);
    chk("R7 mute audio", audioEn, 0);
    chk("R7 mute buffer held", bufConnect, 1);
    chk("R7 R10 mute code", phase, 6);
    @(negedge clk);
    chk("R7 gap", {bufConnect, sinkEn}, 0);
    @(negedge clk);
    chk("R7 sink on", sinkEn, 1);
    pdnBit = 1'b0;
    frames(DS - 1);
    chk("R9 pdn ignored", phase, 6);
    chk("R9 sink held", sinkEn, 1);
    frames(1);
    chk("R9 restart", phase, 4);
    chk("R9 sink off", sinkEn, 0);
    repeat (SH + 5) @(negedge clk);
    chk("R9 active again", phase, 5);
  endtask

  task automatic testAbort();
    softRampEn = 1'b1; pdnBit = 1'b1;
    takeover();
    pdnBit = 1'b0;
    @(negedge clk);
    chk("R6 clamp from idle", phase, 3);
    frames(2);
    pdnBit = 1'b1;
    @(negedge clk);
    chk("R8 clamp abort", phase, 6);
    chk("R8 sink on", {clampEn, sinkEn}, 1);
    frames(DS);
    chk("R9 idle after discharge", phase, 2);
    pdnBit = 1'b0;
    @(negedge clk);
    frames(CL);
    chk("R6 ramp reached", phase, 4);
    frames(2);
    pdnBit = 1'b1;
    @(negedge clk);
    chk("R8 ramp abort", phase, 6);
    chk("R8 ramp off", rampEn, 0);
  endtask

  initial begin
    testStandalone();
    testTakeover();
    testShort();
    testPowerDown();
    testAbort();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule